// File: doc/BRIEF.md
# Speculative Block Frame Allocator

This block hands out physical instruction-buffer frames to blocks of a block-atomic processor. Each fetched block carries, in its header, the number of frames it occupies. The allocator looks for a contiguous run of that many free frames in the requesting thread's share of the pool. If one exists, it records the group as a new architectural frame at the young end of that thread's age-ordered ring. The entry at the old end of each ring is the only non-speculative block. Completing it releases its frames and promotes the next entry. A misprediction names a live block: every block younger than it is discarded and its frames are released.

The pool can run as one ring that owns all frames and all architectural-frame slots. It can also be split ahead of time between two threads, each with its own ring, its own frame range and half of the slots. The split may be even or uneven. The block also forms consumer buffer addresses by placing the producer's architectural-frame ID above the compiler's relative slot offset.

Top module: `fa_frame_alloc`

## Requirements
- R1: After reset both rings are empty, `busy_frames` is 0, both `oldest_afid` values equal their ring's first slot (0 and 16), and neither `alloc_grant` nor `alloc_stall` is high while `alloc_req` is low.
- R2: A request of `alloc_len` frames (1 to 16) is granted in the same cycle when the ring has a free slot and a free contiguous run exists at the candidate base. The candidate is the frame just past the previous allocation of that thread if the run fits below the partition end, and otherwise the partition start. `alloc_base` gives the candidate. `alloc_afid` gives the ring's next slot: ring base plus (head + count) modulo ring size. `live_cnt` rises by one at the next edge.
- R3: A request that cannot be granted raises `alloc_stall` and changes no state. This covers a length of 0 or above 16, a full ring, no room below the partition end, or any occupied frame in the run. Grant and stall are never high together.
- R4: In single mode one ring holds at most 32 live blocks. In threaded mode each ring holds at most 16.
- R5: A commit on a thread with live blocks releases the frames of the oldest block. That ring's `oldest_afid` advances by one slot, with wrap, and its count drops by one. A commit on an empty ring has no effect.
- R6: A squash naming a live block keeps that block and every older one. It discards all younger blocks of that thread and releases their frames. The next allocation of that thread then starts just past the named block's frames. A squash naming a block that is not live has no effect.
- R7: Squash, commit and allocation in the same cycle take effect in that order. An allocation therefore sees the frames and slots freed by the other two.
- R8: With `threaded` low, thread 0 owns frames 0..127 and slots 0..31, and thread 1 requests always stall. With `threaded` high, thread 0 owns frames [0, `split`) and slots 0..15, and thread 1 owns frames [`split`, 128) and slots 16..31. A `split` above 128 counts as 128.
- R9: `cons_addr` equals `{prod_afid, z_off}`: the architectural-frame ID in the upper bits and the relative offset in the lower bits.
- R10: `busy_frames` equals the total length of all live blocks and is 0 whenever both rings are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threaded | input | 1 | 1 = two-thread partition, 0 = single ring |
| split | input | 8 | Frames owned by thread 0 in threaded mode |
| alloc_req | input | 1 | Allocation request |
| alloc_tid | input | 1 | Requesting thread |
| alloc_len | input | 5 | Frame count from block header |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_stall | output | 1 | Request refused this cycle |
| alloc_afid | output | 5 | Architectural-frame ID given to the block |
| alloc_base | output | 7 | First physical frame of the group |
| commit_req | input | 1 | Oldest block of a thread completed |
| commit_tid | input | 1 | Committing thread |
| squash_req | input | 1 | Misprediction |
| squash_tid | input | 1 | Thread of the mispredicted block |
| squash_afid | input | 5 | Mispredicted block's ID (survives) |
| prod_afid | input | 5 | Producer's architectural-frame ID |
| z_off | input | 4 | Compiler-relative slot offset |
| cons_addr | output | 9 | Formed consumer buffer address |
| oldest_afid | output | 2x5 | Non-speculative slot of each ring |
| live_cnt | output | 2x6 | Live blocks per ring |
| busy_frames | output | 8 | Occupied physical frames |

## Verification
The assertions check several properties on every cycle:
- grant and stall are never high together;
- illegal lengths and thread 1 requests in single mode are refused;
- ring counts stay within bounds;
- an isolated grant or commit moves the ring count by exactly one;
- an empty pool reports no busy frames.

Only the bench's scenarios can show the rest. This includes:
- placement: wrap to the partition start, refusal when the run collides with live frames;
- squash behaviour: which groups a squash discards, and where the frame tail then lands;
- the squash-commit-allocate order within one cycle;
- the exact frame ranges of uneven thread splits.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int FRAMES = 128;
    localparam int MAXGRP = 16;
    localparam int NAF    = 32;
    localparam int NTHR   = 2;
    localparam int FW     = $clog2(FRAMES);
    localparam int PW     = FW + 1;
    localparam int LW     = $clog2(MAXGRP + 1);
    localparam int AW     = $clog2(NAF);
    localparam int CW     = AW + 1;
    localparam int HALF   = NAF / NTHR;

    typedef struct packed {
        logic          vld;
        logic [FW-1:0] base;
        logic [LW-1:0] len;
    } grp_t;

    typedef struct packed {
        logic [AW-1:0] head;
        logic [CW-1:0] cnt;
        logic [PW-1:0] ftail;
    } ring_t;

    typedef struct packed {
        grp_t  [NAF-1:0]  grp;
        ring_t [NTHR-1:0] ring;
        logic  [FRAMES-1:0] occ;
    } st_t;

    function automatic logic [FRAMES-1:0] span_mask(input logic [PW-1:0] base,
                                                    input logic [LW-1:0] len);
        logic [FRAMES-1:0] m;
        for (int i = 0; i < FRAMES; i++) begin
            m[i] = (i >= int'(base)) && (i < int'(base) + int'(len));
        end
        return m;
    endfunction
endpackage

// File: rtl/fa_span_mask.sv
module fa_span_mask
    import fa_pkg::*;
(
    input  logic              en,
    input  logic [FW-1:0]     base,
    input  logic [LW-1:0]     len,
    output logic [FRAMES-1:0] mask
);
    always_comb begin
        mask = en ? span_mask({1'b0, base}, len) : '0;
    end
endmodule

// File: rtl/fa_addr_form.sv
module fa_addr_form #(
    parameter int ID_W   = 5,
    parameter int ZOFF_W = 4
) (
    input  logic [ID_W-1:0]        afid,
    input  logic [ZOFF_W-1:0]      zoff,
    output logic [ID_W+ZOFF_W-1:0] addr
);
    assign addr = {afid, zoff};
endmodule

// File: rtl/fa_frame_alloc.sv
module fa_frame_alloc
    import fa_pkg::*;
#(
    parameter int ZOFF_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       threaded,
    input  logic [PW-1:0]              split,
    input  logic                       alloc_req,
    input  logic                       alloc_tid,
    input  logic [LW-1:0]              alloc_len,
    output logic                       alloc_grant,
    output logic                       alloc_stall,
    output logic [AW-1:0]              alloc_afid,
    output logic [FW-1:0]              alloc_base,
    input  logic                       commit_req,
    input  logic                       commit_tid,
    input  logic                       squash_req,
    input  logic                       squash_tid,
    input  logic [AW-1:0]              squash_afid,
    input  logic [AW-1:0]              prod_afid,
    input  logic [ZOFF_W-1:0]          z_off,
    output logic [AW+ZOFF_W-1:0]       cons_addr,
    output logic [NTHR-1:0][AW-1:0]    oldest_afid,
    output logic [NTHR-1:0][CW-1:0]    live_cnt,
    output logic [PW-1:0]              busy_frames
);
    st_t st_q, st_d;

    // Per-group frame masks from registered state
    logic [NAF-1:0][FRAMES-1:0] gmask;
    for (genvar g = 0; g < NAF; g++) begin : g_mask
        fa_span_mask u_mask (
            .en   (st_q.grp[g].vld),
            .base (st_q.grp[g].base),
            .len  (st_q.grp[g].len),
            .mask (gmask[g])
        );
    end

    // Static partition geometry
    logic [PW-1:0]             sp;
    logic [NTHR-1:0][PW-1:0]   p_lo, p_hi;
    logic [NTHR-1:0][AW-1:0]   r_base, r_msk;
    logic [NTHR-1:0][CW-1:0]   r_size;
    logic [NTHR-1:0]           t_en;

    always_comb begin
        sp        = (split > PW'(FRAMES)) ? PW'(FRAMES) : split;
        p_lo[0]   = '0;
        p_hi[0]   = threaded ? sp : PW'(FRAMES);
        r_base[0] = '0;
        r_size[0] = threaded ? CW'(HALF) : CW'(NAF);
        t_en[0]   = 1'b1;
        p_lo[1]   = sp;
        p_hi[1]   = PW'(FRAMES);
        r_base[1] = AW'(HALF);
        r_size[1] = CW'(HALF);
        t_en[1]   = threaded;
        for (int t = 0; t < NTHR; t++) begin
            r_msk[t] = AW'(r_size[t] - CW'(1));
        end
    end

    // Next-state: squash, then commit, then allocate
    logic [AW-1:0]     sq_loc, sq_pos, e_rel, e_pos, cm_slot, al_slot;
    logic [PW:0]       al_cand, ft_ext;
    logic [FRAMES-1:0] al_mask;
    logic              al_fit;

    always_comb begin
        st_d    = st_q;
        sq_loc  = '0;
        sq_pos  = '0;
        e_rel   = '0;
        e_pos   = '0;
        cm_slot = '0;
        al_slot = '0;
        al_cand = '0;
        ft_ext  = '0;
        al_mask = '0;
        al_fit  = 1'b0;

        if (squash_req && t_en[squash_tid]) begin
            sq_loc = squash_afid - r_base[squash_tid];
            sq_pos = (sq_loc - st_q.ring[squash_tid].head) & r_msk[squash_tid];
            if (CW'(sq_loc) < r_size[squash_tid] &&
                CW'(sq_pos) < st_q.ring[squash_tid].cnt) begin
                for (int s = 0; s < NAF; s++) begin
                    e_rel = AW'(s) - r_base[squash_tid];
                    e_pos = (e_rel - st_q.ring[squash_tid].head) & r_msk[squash_tid];
                    if (CW'(e_rel) < r_size[squash_tid] && e_pos > sq_pos &&
                        CW'(e_pos) < st_q.ring[squash_tid].cnt) begin
                        st_d.grp[s].vld = 1'b0;
                        st_d.occ        = st_d.occ & ~gmask[s];
                    end
                end
                st_d.ring[squash_tid].cnt   = CW'(sq_pos) + CW'(1);
                st_d.ring[squash_tid].ftail = PW'(st_q.grp[squash_afid].base) +
                                              PW'(st_q.grp[squash_afid].len);
            end
        end

        if (commit_req && t_en[commit_tid] && st_d.ring[commit_tid].cnt != '0) begin
            cm_slot                    = r_base[commit_tid] + st_d.ring[commit_tid].head;
            st_d.grp[cm_slot].vld      = 1'b0;
            st_d.occ                   = st_d.occ & ~gmask[cm_slot];
            st_d.ring[commit_tid].head = (st_d.ring[commit_tid].head + AW'(1)) &
                                         r_msk[commit_tid];
            st_d.ring[commit_tid].cnt  = st_d.ring[commit_tid].cnt - CW'(1);
        end

        ft_ext  = {1'b0, st_d.ring[alloc_tid].ftail};
        if (ft_ext >= {1'b0, p_lo[alloc_tid]} &&
            ft_ext + (PW+1)'(alloc_len) <= {1'b0, p_hi[alloc_tid]}) begin
            al_cand = ft_ext;
        end else begin
            al_cand = {1'b0, p_lo[alloc_tid]};
        end
        al_mask = span_mask(al_cand[PW-1:0], alloc_len);
        al_fit  = alloc_req && t_en[alloc_tid] && alloc_len != '0 &&
                  alloc_len <= LW'(MAXGRP) &&
                  st_d.ring[alloc_tid].cnt < r_size[alloc_tid] &&
                  al_cand + (PW+1)'(alloc_len) <= {1'b0, p_hi[alloc_tid]} &&
                  (st_d.occ & al_mask) == '0;
        al_slot = r_base[alloc_tid] +
                  ((st_d.ring[alloc_tid].head + AW'(st_d.ring[alloc_tid].cnt)) &
                   r_msk[alloc_tid]);
        if (al_fit) begin
            st_d.grp[al_slot].vld      = 1'b1;
            st_d.grp[al_slot].base     = al_cand[FW-1:0];
            st_d.grp[al_slot].len      = alloc_len;
            st_d.occ                   = st_d.occ | al_mask;
            st_d.ring[alloc_tid].cnt   = st_d.ring[alloc_tid].cnt + CW'(1);
            st_d.ring[alloc_tid].ftail = PW'(al_cand + (PW+1)'(alloc_len));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_grant = al_fit;
    assign alloc_stall = alloc_req && !al_fit;
    assign alloc_afid  = al_slot;
    assign alloc_base  = al_cand[FW-1:0];
    assign busy_frames = PW'($countones(st_q.occ));

    for (genvar t = 0; t < NTHR; t++) begin : g_out
        assign oldest_afid[t] = r_base[t] + st_q.ring[t].head;
        assign live_cnt[t]    = st_q.ring[t].cnt;
    end

    fa_addr_form #(.ID_W(AW), .ZOFF_W(ZOFF_W)) u_addr (
        .afid (prod_afid),
        .zoff (z_off),
        .addr (cons_addr)
    );
endmodule

// File: rtl/fa_frame_alloc_chk.sv
module fa_frame_alloc_chk
    import fa_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    threaded,
    input logic                    alloc_req,
    input logic                    alloc_tid,
    input logic [LW-1:0]           alloc_len,
    input logic                    alloc_grant,
    input logic                    alloc_stall,
    input logic                    commit_req,
    input logic                    commit_tid,
    input logic                    squash_req,
    input logic [NTHR-1:0][CW-1:0] live_cnt,
    input logic [PW-1:0]           busy_frames
);
    // R3
    grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_grant && alloc_stall));

    // R3
    bad_len_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && (alloc_len == '0 || alloc_len > LW'(MAXGRP)) |-> alloc_stall);

    // R4
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt[1] <= CW'(HALF) && live_cnt[0] <= CW'(NAF) &&
        (!threaded || live_cnt[0] <= CW'(HALF)));

    // R2
    grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant && !commit_req && !squash_req |=>
        live_cnt[$past(alloc_tid)] == $past(live_cnt[alloc_tid]) + CW'(1));

    // R5
    commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req && live_cnt[commit_tid] != '0 && !squash_req && !alloc_req |=>
        live_cnt[$past(commit_tid)] == $past(live_cnt[commit_tid]) - CW'(1));

    // R8
    single_t1_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !threaded && alloc_req && alloc_tid |-> alloc_stall);

    // R10
    empty_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt[0] == '0 && live_cnt[1] == '0 |-> busy_frames == '0);
endmodule

bind fa_frame_alloc fa_frame_alloc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .threaded    (threaded),
    .alloc_req   (alloc_req),
    .alloc_tid   (alloc_tid),
    .alloc_len   (alloc_len),
    .alloc_grant (alloc_grant),
    .alloc_stall (alloc_stall),
    .commit_req  (commit_req),
    .commit_tid  (commit_tid),
    .squash_req  (squash_req),
    .live_cnt    (live_cnt),
    .busy_frames (busy_frames)
);

// File: tb/tb_fa_frame_alloc.sv
`timescale 1ns/1ps
module tb_fa_frame_alloc;
    logic clk = 0, rst_n = 0, threaded = 0;
    logic [7:0] split = 8'd64;
    logic alloc_req = 0, alloc_tid = 0, commit_req = 0, commit_tid = 0;
    logic squash_req = 0, squash_tid = 0;
    logic [4:0] alloc_len = 0, squash_afid = 0, prod_afid = 0, alloc_afid;
    logic [3:0] z_off = 0;
    logic [6:0] alloc_base;
    logic [8:0] cons_addr;
    logic alloc_grant, alloc_stall;
    logic [1:0][4:0] oldest_afid;
    logic [1:0][5:0] live_cnt;
    logic [7:0] busy_frames;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    fa_frame_alloc dut (.*);

    // reference model state
    int m_head[2], m_cnt[2], m_ftail[2], m_base[32], m_len[32];
    bit m_occ[128];
    int spl;

    function automatic int rsz(int t); return (t == 0) ? (threaded ? 16 : 32) : 16; endfunction
    function automatic int rbs(int t); return (t == 0) ? 0 : 16; endfunction
    function automatic int plo(int t); return (t == 0) ? 0 : spl; endfunction
    function automatic int phi(int t); return (t == 0) ? (threaded ? spl : 128) : 128; endfunction
    function automatic bit ten(int t); return (t == 0) ? 1'b1 : threaded; endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic free_grp(int s);
        for (int f = m_base[s]; f < m_base[s] + m_len[s]; f++) m_occ[f] = 0;
    endtask

    task automatic m_squash(int t, int a);
        int loc, pa, s;
        if (!ten(t)) return;
        loc = (a - rbs(t)) & 31;
        if (loc >= rsz(t)) return;
        pa = (loc - m_head[t]) & (rsz(t) - 1);
        if (pa >= m_cnt[t]) return;
        for (int k = pa + 1; k < m_cnt[t]; k++) begin
            s = rbs(t) + ((m_head[t] + k) & (rsz(t) - 1));
            free_grp(s);
        end
        m_cnt[t] = pa + 1;
        m_ftail[t] = m_base[a] + m_len[a];
    endtask

    task automatic m_commit(int t);
        if (!ten(t) || m_cnt[t] == 0) return;
        free_grp(rbs(t) + m_head[t]);
        m_head[t] = (m_head[t] + 1) & (rsz(t) - 1);
        m_cnt[t]--;
    endtask

    task automatic m_reset();
        for (int t = 0; t < 2; t++) begin m_head[t] = 0; m_cnt[t] = 0; m_ftail[t] = 0; end
        for (int f = 0; f < 128; f++) m_occ[f] = 0;
    endtask

    task automatic do_reset(bit thr, int sp);
        @(negedge clk);
        rst_n = 0; threaded = thr; split = 8'(sp);
        spl = (sp > 128) ? 128 : sp;
        alloc_req = 0; commit_req = 0; squash_req = 0;
        m_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 busy", busy_frames, 0);
        chk("R1 cnt0", live_cnt[0], 0);
        chk("R1 cnt1", live_cnt[1], 0);
        chk("R1 oldest0", oldest_afid[0], 0);
        chk("R1 oldest1", oldest_afid[1], 16);
        chk("R1 grant", alloc_grant, 0);
        chk("R1 stall", alloc_stall, 0);
    endtask

    task automatic cycle(bit ar, int at, int al, bit cr, int ct, bit sr, int st, int sa);
        int cand, exp_af, busy;
        bit fit;
        @(negedge clk);
        alloc_req = ar; alloc_tid = at[0]; alloc_len = 5'(al);
        commit_req = cr; commit_tid = ct[0];
        squash_req = sr; squash_tid = st[0]; squash_afid = 5'(sa);
        #1;
        // R7 order: squash, commit, then allocation
        if (sr) m_squash(st, sa);
        if (cr) m_commit(ct);
        cand = (m_ftail[at] >= plo(at) && m_ftail[at] + al <= phi(at)) ? m_ftail[at] : plo(at);
        fit = ar && ten(at) && al >= 1 && al <= 16 && m_cnt[at] < rsz(at) && cand + al <= phi(at);
        if (fit) for (int f = cand; f < cand + al; f++) if (m_occ[f]) fit = 0;
        exp_af = rbs(at) + ((m_head[at] + m_cnt[at]) & (rsz(at) - 1));
        chk("R2 grant", alloc_grant, fit);
        chk("R3 stall", alloc_stall, ar && !fit);
        if (fit) begin
            chk("R2 afid", alloc_afid, exp_af);
            chk("R2 base", alloc_base, cand);
            m_base[exp_af] = cand; m_len[exp_af] = al;
            for (int f = cand; f < cand + al; f++) m_occ[f] = 1;
            m_cnt[at]++;
            m_ftail[at] = cand + al;
        end
        @(posedge clk);
        #1;
        busy = 0;
        for (int f = 0; f < 128; f++) busy += m_occ[f];
        chk("R4 R6 cnt0", live_cnt[0], m_cnt[0]);
        chk("R4 R6 cnt1", live_cnt[1], m_cnt[1]);
        chk("R5 oldest0", oldest_afid[0], rbs(0) + m_head[0]);
        chk("R5 oldest1", oldest_afid[1], rbs(1) + m_head[1]);
        chk("R10 busy", busy_frames, busy);
    endtask

    task automatic rnd_cycles(int n);
        int at, ct, st, sa, al;
        bit ar, cr, sr;
        for (int i = 0; i < n; i++) begin
            at = threaded ? int'($urandom_range(0, 1)) : (($urandom_range(0, 19) == 0) ? 1 : 0);
            al = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 31)) : int'($urandom_range(1, 16));
            ar = $urandom_range(0, 9) < 6;
            ct = threaded ? int'($urandom_range(0, 1)) : 0;
            cr = $urandom_range(0, 9) < 3;
            st = threaded ? int'($urandom_range(0, 1)) : 0;
            sr = $urandom_range(0, 9) == 0;
            if (m_cnt[st] > 0)
                sa = rbs(st) + ((m_head[st] + int'($urandom_range(0, m_cnt[st] - 1))) & (rsz(st) - 1));
            else
                sa = int'($urandom_range(0, 31));
            cycle(ar, at, al, cr, ct, sr, st, sa);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(0, 64);
        // R2 fill the pool with full-size groups, R3 then stall
        for (int i = 0; i < 8; i++) cycle(1, 0, 16, 0, 0, 0, 0, 0);
        cycle(1, 0, 1, 0, 0, 0, 0, 0);
        // R5 commit then wrap to partition start (R2)
        cycle(0, 0, 0, 1, 0, 0, 0, 0);
        cycle(1, 0, 16, 0, 0, 0, 0, 0);
        // R3 illegal lengths, R8 thread 1 in single mode
        cycle(1, 0, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 17, 0, 0, 0, 0, 0);
        cycle(1, 1, 4, 0, 0, 0, 0, 0);
        // R5 commit on empty ring ignored
        do_reset(0, 64);
        cycle(0, 0, 0, 1, 0, 0, 0, 0);
        // R6 squash keeps named block, drops younger ones
        for (int i = 0; i < 4; i++) cycle(1, 0, 2, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 1);
        chk("R6 busy after squash", busy_frames, 4);
        cycle(1, 0, 3, 0, 0, 0, 0, 0);
        // R6 squash of a block that is not live
        cycle(0, 0, 0, 0, 0, 1, 0, 20);
        // R7 squash, commit and allocate together
        cycle(1, 0, 5, 1, 0, 1, 0, 1);
        // R4 ring fills at 32 single-frame blocks
        do_reset(0, 64);
        for (int i = 0; i < 33; i++) cycle(1, 0, 1, 0, 0, 0, 0, 0);
        // R9 consumer address formation
        for (int i = 0; i < 4; i++) begin
            prod_afid = 5'($urandom_range(0, 31));
            z_off = 4'($urandom_range(0, 15));
            #1;
            chk("R9 cons_addr", cons_addr, {prod_afid, z_off});
        end
        rnd_cycles(3000);
        // R8 even and uneven threaded partitions
        do_reset(1, 64);
        for (int i = 0; i < 17; i++) cycle(1, 1, 1, 0, 0, 0, 0, 0);
        rnd_cycles(3000);
        do_reset(1, 40);
        rnd_cycles(3000);
        do_reset(1, 200);
        rnd_cycles(500);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule